// File: doc/BRIEF.md
# Transmit Timestamp Adjuster for a Two-Lane 64-bit Ethernet Path

This block gives each outgoing frame a transmit timestamp. The 64-bit transmit datapath can start a frame in the low 32-bit lane or in the high 32-bit lane. The cycle that begins a frame raises a start strobe and a lane select. On that strobe the block takes a copy of the free-running time-of-day. It adds the latency between that cycle and the moment the frame start reaches the line. That latency is one clock period for a low-lane start and one and a half periods for a high-lane start.

A second register stage brings the nanosecond field back into range. If the adjusted nanoseconds reach one billion, the stage subtracts one billion and carries one second into the seconds field. It then publishes the timestamp, a tag taken from the frame's user word, and a one-cycle valid pulse. The two stages are separate, so a frame may start on every clock: each capture moves on to the publish stage one cycle later and cannot be overwritten there.

The default timestamp has 96 bits: seconds in bits 95:48, two zero bits at 47:46, whole nanoseconds in 45:16 and fractional nanoseconds in 15:0. With any other width, the offset is added to the whole word and the publish stage does no rollover.

Top module: `ptp_egress_stamp`

## Requirements
- R1: After reset, and while reset is held, `tsValid` is 0 and `tsOut` and `tagOut` are all zero. A capture that is pending when reset arrives never produces a pulse.
- R2: For a start with `startHigh`=0, the published bits 45:0 equal the sampled time-of-day bits 45:0 plus one clock period. With the defaults the period is 0x66666 (6 ns plus 0x6666 fractional). The seconds field is copied unchanged from the sample unless R4 applies.
- R3: For a start with `startHigh`=1, the offset is one and a half periods (0x99999 with the defaults). It is added to the same bit range in the same way as in R2.
- R4: If the adjusted nanosecond field (bits 45:16) is 1,000,000,000 or more, the published value has 1,000,000,000 subtracted from it and has the seconds field (bits 95:48) incremented by one. A value of exactly one billion is published as 0. The fractional bits 15:0 pass through unchanged.
- R5: If the adjusted nanosecond field is below one billion, the publish stage leaves the nanosecond and seconds fields as they were captured.
- R6: The strobe is sampled at clock edge N. At edge N+1, `tsValid` rises for exactly one cycle, and `tsOut` and `tagOut` carry that frame's values at the same time.
- R7: `tagOut` equals the user word shifted right by one bit. Bit 0 of the user word, the frame error flag, has no effect on the tag.
- R8: Strobes on consecutive cycles give consecutive valid pulses, in strobe order, each carrying its own timestamp and tag. This holds even when the earlier frame needs a rollover in the same cycle as the later frame's capture.
- R9: The offset addition wraps within bits 45:0 and never carries into bits 47:46 or the seconds field. Output bits 47:46 are always 0.
- R10: While `tsValid` is 0, `tsOut` and `tagOut` hold their last published values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the transmit datapath |
| rst | input | 1 | Synchronous active-high reset |
| todIn | input | TS_WIDTH | Free-running time-of-day |
| startStrobe | input | 1 | High for one cycle when a frame begins |
| startHigh | input | 1 | 1 = the frame begins in the high 32-bit lane |
| userWord | input | USER_WIDTH | Bit 0 is the frame error flag; the bits above it carry the tag |
| tsOut | output | TS_WIDTH | Published transmit timestamp |
| tagOut | output | TAG_WIDTH | Published tag |
| tsValid | output | 1 | One-cycle pulse marking a new timestamp |

## Verification
Two functions can fall in the same clock cycle: the rollover fold of one frame in the publish stage, and the capture of the next frame in the capture stage. The bench provokes this with a frame whose adjusted nanoseconds come to exactly one billion, followed on the very next cycle by a frame in the other lane. It then checks that two pulses appear on consecutive cycles. The first pulse must carry the folded value with the seconds field incremented. The second must carry its own unfolded offset timestamp and its own tag.

// File: rtl/ptp_egress_pkg.sv
package ptp_egress_pkg;
  typedef struct packed {
    logic capture;   // sample time-of-day this cycle
    logic laneHigh;  // capture uses the one-and-a-half period offset
    logic publish;   // move the captured value to the outputs
  } tsStrobe_t;

  localparam logic [29:0] NS_PER_SEC = 30'd1000000000;
endpackage

// File: rtl/ptp_egress_ctrl.sv
module ptp_egress_ctrl
  import ptp_egress_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startStrobe,
  input  logic      startHigh,
  output tsStrobe_t strobes,
  output logic      validOut
);
  logic pendQ;
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      pendQ  <= startStrobe;
      validQ <= pendQ;
    end
  end

  always_comb begin
    strobes.capture  = startStrobe;
    strobes.laneHigh = startHigh;
    strobes.publish  = pendQ;
  end

  assign validOut = validQ;
endmodule

// File: rtl/ptp_egress_dpath.sv
module ptp_egress_dpath
  import ptp_egress_pkg::*;
#(
  parameter int          TS_WIDTH   = 96,
  parameter logic [3:0]  PERIOD_NS  = 4'h6,
  parameter logic [15:0] PERIOD_FNS = 16'h6666,
  parameter bit          TAG_EN     = 1'b1,
  parameter int          TAG_WIDTH  = 16,
  parameter int          USER_WIDTH = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  tsStrobe_t             strobes,
  input  logic [TS_WIDTH-1:0]   todIn,
  input  logic [USER_WIDTH-1:0] userWord,
  output logic [TS_WIDTH-1:0]   tsOut,
  output logic [TAG_WIDTH-1:0]  tagOut
);
  localparam int unsigned PERIOD_FULL = int'(PERIOD_NS) * 65536 + int'(PERIOD_FNS);
  localparam int unsigned PERIOD_HALF = (PERIOD_FULL * 3) / 2;

  logic [TS_WIDTH-1:0]  capQ, capNext;
  logic [TS_WIDTH-1:0]  foldVal;
  logic [TAG_WIDTH-1:0] tagCapQ, tagNext;
  logic [TS_WIDTH-1:0]  outQ;
  logic [TAG_WIDTH-1:0] tagOutQ;

  generate
    if (TS_WIDTH == 96) begin : g_split
      localparam logic [45:0] OFF_LO = 46'(PERIOD_FULL);
      localparam logic [45:0] OFF_HI = 46'(PERIOD_HALF);
      logic [45:0] offSel;
      logic [29:0] capNs;
      logic        overNs;

      assign offSel  = strobes.laneHigh ? OFF_HI : OFF_LO;
      assign capNext = {todIn[95:48], 2'b00, todIn[45:0] + offSel};
      assign capNs   = capQ[45:16];
      assign overNs  = (capNs >= NS_PER_SEC);
      assign foldVal = overNs ?
                       {capQ[95:48] + 48'd1, 2'b00, capNs - NS_PER_SEC, capQ[15:0]} :
                       capQ;
    end else begin : g_flat
      localparam logic [TS_WIDTH-1:0] OFF_LO = TS_WIDTH'(PERIOD_FULL);
      localparam logic [TS_WIDTH-1:0] OFF_HI = TS_WIDTH'(PERIOD_HALF);
      assign capNext = todIn + (strobes.laneHigh ? OFF_HI : OFF_LO);
      assign foldVal = capQ;
    end

    if (TAG_EN && USER_WIDTH > 1) begin : g_tag
      assign tagNext = TAG_WIDTH'(userWord[USER_WIDTH-1:1]);
    end else begin : g_notag
      assign tagNext = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      capQ    <= '0;
      tagCapQ <= '0;
      outQ    <= '0;
      tagOutQ <= '0;
    end else begin
      if (strobes.capture) begin
        capQ    <= capNext;
        tagCapQ <= tagNext;
      end
      if (strobes.publish) begin
        outQ    <= foldVal;
        tagOutQ <= tagCapQ;
      end
    end
  end

  assign tsOut  = outQ;
  assign tagOut = tagOutQ;
endmodule

// File: rtl/ptp_egress_stamp.sv
module ptp_egress_stamp
  import ptp_egress_pkg::*;
#(
  parameter int          TS_WIDTH   = 96,
  parameter logic [3:0]  PERIOD_NS  = 4'h6,
  parameter logic [15:0] PERIOD_FNS = 16'h6666,
  parameter bit          TS_ENABLE  = 1'b1,
  parameter bit          TAG_ENABLE = 1'b1,
  parameter int          TAG_WIDTH  = 16,
  parameter int          USER_WIDTH = ((TS_ENABLE && TAG_ENABLE) ? TAG_WIDTH : 0) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TS_WIDTH-1:0]   todIn,
  input  logic                  startStrobe,
  input  logic                  startHigh,
  input  logic [USER_WIDTH-1:0] userWord,
  output logic [TS_WIDTH-1:0]   tsOut,
  output logic [TAG_WIDTH-1:0]  tagOut,
  output logic                  tsValid
);
  tsStrobe_t            strobes;
  logic                 validInt;
  logic [TS_WIDTH-1:0]  tsInt;
  logic [TAG_WIDTH-1:0] tagInt;

  ptp_egress_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .startStrobe (startStrobe),
    .startHigh   (startHigh),
    .strobes     (strobes),
    .validOut    (validInt)
  );

  ptp_egress_dpath #(
    .TS_WIDTH   (TS_WIDTH),
    .PERIOD_NS  (PERIOD_NS),
    .PERIOD_FNS (PERIOD_FNS),
    .TAG_EN     (TS_ENABLE && TAG_ENABLE),
    .TAG_WIDTH  (TAG_WIDTH),
    .USER_WIDTH (USER_WIDTH)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .todIn    (todIn),
    .userWord (userWord),
    .tsOut    (tsInt),
    .tagOut   (tagInt)
  );

  generate
    if (TS_ENABLE) begin : g_on
      assign tsOut   = tsInt;
      assign tagOut  = TAG_ENABLE ? tagInt : '0;
      assign tsValid = validInt;
    end else begin : g_off
      assign tsOut   = '0;
      assign tagOut  = '0;
      assign tsValid = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ptp_egress_stamp_chk.sv
module ptp_egress_stamp_chk #(
  parameter int TS_WIDTH   = 96,
  parameter bit TS_ENABLE  = 1'b1,
  parameter bit TAG_ENABLE = 1'b1,
  parameter int TAG_WIDTH  = 16,
  parameter int USER_WIDTH = 17
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  startStrobe,
  input logic [USER_WIDTH-1:0] userWord,
  input logic [TS_WIDTH-1:0]   tsOut,
  input logic [TAG_WIDTH-1:0]  tagOut,
  input logic                  tsValid
);
  logic [1:0] ageQ;

  always_ff @(posedge clk) begin
    if (rst) ageQ <= 2'd0;
    else if (ageQ != 2'd3) ageQ <= ageQ + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !tsValid);

  p_no_valid_reset_r1: assert property (@(posedge clk) rst |-> !tsValid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ageQ >= 2'd1 && !tsValid) |-> ($stable(tsOut) && $stable(tagOut)));

  generate
    if (TS_ENABLE) begin : g_ts
      p_pulse_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (ageQ >= 2'd2 && $past(startStrobe, 2)) |-> tsValid);

      p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (ageQ >= 2'd2 && tsValid) |-> $past(startStrobe, 2));

      if (TS_WIDTH == 96) begin : g_96
        p_ns_range_r4: assert property (@(posedge clk) disable iff (rst)
          tsValid |-> (tsOut[45:16] < 30'd1000000000));

        p_gap_zero_r9: assert property (@(posedge clk) disable iff (rst)
          tsOut[47:46] == 2'b00);
      end

      if (TAG_ENABLE && USER_WIDTH > 1) begin : g_tag
        p_tag_shift_r7: assert property (@(posedge clk) disable iff (rst)
          (ageQ >= 2'd2 && tsValid) |->
          (tagOut == TAG_WIDTH'($past(userWord, 2) >> 1)));
      end
    end
  endgenerate
endmodule

bind ptp_egress_stamp ptp_egress_stamp_chk #(
  .TS_WIDTH   (TS_WIDTH),
  .TS_ENABLE  (TS_ENABLE),
  .TAG_ENABLE (TAG_ENABLE),
  .TAG_WIDTH  (TAG_WIDTH),
  .USER_WIDTH (USER_WIDTH)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .startStrobe (startStrobe),
  .userWord    (userWord),
  .tsOut       (tsOut),
  .tagOut      (tagOut),
  .tsValid     (tsValid)
);

// File: tb/ptp_egress_stamp_tb.sv
module ptp_egress_stamp_tb_top;
  localparam int NV = 6;

  // stimulus: seconds, nanoseconds, fraction, lane, user word
  localparam logic [47:0] V_SEC  [NV] = '{48'd5, 48'd7, 48'd3, 48'd10, 48'd1, 48'd9};
  localparam logic [29:0] V_NS   [NV] = '{30'd100, 30'd200, 30'd999999994,
                                          30'd999999999, 30'd999999993, 30'h3FFFFFFF};
  localparam logic [15:0] V_FR   [NV] = '{16'h0000, 16'h8000, 16'h0000,
                                          16'hFFFF, 16'h9999, 16'hFFFF};
  localparam logic        V_HI   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [16:0] V_USER [NV] = '{17'h000A5, 17'h01235, 17'h1FFFF,
                                          17'h00001, 17'h10000, 17'h0ABCD};
  // expected: seconds, nanoseconds, fraction, tag
  localparam logic [47:0] E_SEC  [NV] = '{48'd5, 48'd7, 48'd4, 48'd11, 48'd1, 48'd9};
  localparam logic [29:0] E_NS   [NV] = '{30'd106, 30'd210, 30'd0,
                                          30'd9, 30'd999999999, 30'd6};
  localparam logic [15:0] E_FR   [NV] = '{16'h6666, 16'h1999, 16'h6666,
                                          16'h9998, 16'hFFFF, 16'h6665};
  localparam logic [15:0] E_TAG  [NV] = '{16'h0052, 16'h091A, 16'hFFFF,
                                          16'h0000, 16'h8000, 16'h55E6};
  localparam string       V_REQ  [NV] = '{"R2", "R3", "R4", "R4", "R5", "R9"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] todIn = '0;
  logic        startStrobe = 1'b0;
  logic        startHigh = 1'b0;
  logic [16:0] userWord = '0;
  logic [95:0] tsOut;
  logic [15:0] tagOut;
  logic        tsValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptp_egress_stamp dut_i (
    .clk         (clk),
    .rst         (rst),
    .todIn       (todIn),
    .startStrobe (startStrobe),
    .startHigh   (startHigh),
    .userWord    (userWord),
    .tsOut       (tsOut),
    .tagOut      (tagOut),
    .tsValid     (tsValid)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mkTs(input logic [47:0] s, input logic [29:0] n,
                                       input logic [15:0] f);
    return {s, 2'b00, n, f};
  endfunction

  task automatic drive(input int i);
    todIn       = mkTs(V_SEC[i], V_NS[i], V_FR[i]);
    startHigh   = V_HI[i];
    userWord    = V_USER[i];
    startStrobe = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 while reset held
    check("R1 valid in reset", 128'(tsValid), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ts after reset", 128'(tsOut), 128'd0);
    check("R1 tag after reset", 128'(tagOut), 128'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      drive(i);
      @(negedge clk);
      startStrobe = 1'b0;
      todIn = 96'h1234_5678_9ABC_DEF0_1357_9BDF;
      userWord = 17'h15555;
      check("R6 no early pulse", 128'(tsValid), 128'd0);
      @(negedge clk);
      check("R6 pulse", 128'(tsValid), 128'd1);
      check(V_REQ[i], 128'(tsOut), 128'(mkTs(E_SEC[i], E_NS[i], E_FR[i])));
      check("R7 tag", 128'(tagOut), 128'(E_TAG[i]));
      @(negedge clk);
      check("R6 single pulse", 128'(tsValid), 128'd0);
      check("R10 hold", 128'(tsOut), 128'(mkTs(E_SEC[i], E_NS[i], E_FR[i])));
      @(negedge clk);
    end

    // R8: rollover frame then a high-lane frame on the next cycle
    drive(2);
    @(negedge clk);
    drive(1);
    @(negedge clk);
    startStrobe = 1'b0;
    check("R8 first pulse", 128'(tsValid), 128'd1);
    check("R8 first folded ts", 128'(tsOut), 128'(mkTs(E_SEC[2], E_NS[2], E_FR[2])));
    check("R8 first tag", 128'(tagOut), 128'(E_TAG[2]));
    @(negedge clk);
    check("R8 second pulse", 128'(tsValid), 128'd1);
    check("R8 second ts", 128'(tsOut), 128'(mkTs(E_SEC[1], E_NS[1], E_FR[1])));
    check("R8 second tag", 128'(tagOut), 128'(E_TAG[1]));
    @(negedge clk);
    check("R8 pulses end", 128'(tsValid), 128'd0);

    // R1: reset while a capture is pending
    drive(0);
    @(negedge clk);
    startStrobe = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 pending dropped", 128'(tsValid), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 no late pulse", 128'(tsValid), 128'd0);
    check("R1 ts cleared", 128'(tsOut), 128'd0);
    @(negedge clk);
    check("R1 still quiet", 128'(tsValid), 128'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule